// File: doc/BRIEF.md
# PTP Event Frame Timestamp Capture Unit

This unit sits beside one switch port and records when precision-time event frames pass through it. A free-running time counter advances once per clock. When a frame-start strobe arrives on the receive or transmit side, together with the already parsed EtherType, 4-bit message type and sequence identifier, the unit checks whether the frame qualifies. If it does, the unit latches the counter value and the sequence identifier into a capture record. There are two arrival records and one departure record. A per-type steering mask can send some receive message types, typically the peer-delay response (type 3), to the second arrival record. Every other qualifying arrival goes to the first.

Each record holds one timestamp at a time. Software reads a record as four 16-bit words: status, time low half, time high half, sequence ID. It frees the record by writing zero to the status word. A frame that qualifies while its record still holds an unread capture does not overwrite it. The old time and sequence ID stay in place, and the status field changes to an overrun code so that software knows the stamp can no longer be paired with certainty. Global registers select the EtherType to match, the message types to capture and the steering. A global switch and a per-port switch turn capture off.

Top module: `ptp_stamp_unit`

## Requirements
- R1: The time counter `cur_time` is 0 in reset and increases by exactly 1 on every clock edge after reset.
- R2: Reset values:
  - control register (addr 0x00, bit0 = global off) reads 0x0001.
  - EtherType register (0x01) reads 0x88F7.
  - capture mask (0x02, bit n enables message type n) reads 0x000F.
  - steering mask (0x03, bit n sends arrivals of type n to the second arrival record) reads 0x0000.
  - port config (0x04, bit0 = port off) reads 0x0001.
  - all record words read 0.
- R3: A read returns its data on `reg_rdata` one clock after the edge that samples `reg_rd`, and `reg_rdata` keeps its old value until then. Record layout:
  - the first arrival record is at 0x10, the second arrival record at 0x14, the departure record at 0x18.
  - word +0 is status, +1 is time[15:0], +2 is time[31:16], +3 is the sequence ID.
  - in the status word, bit0 is valid and bits 2:1 are the status field.
  - unmapped addresses read 0.
- R4: An arrival qualifies when `rx_sof` is high, `rx_etype` equals the EtherType register, the capture-mask bit for `rx_msgtype` is set and both off bits are 0. A qualifying arrival into an empty record sets valid, sets the status field to 00, and stores `rx_seqid` and the `cur_time` value of the strobe cycle.
- R5: A qualifying arrival whose steering-mask bit is set (for example bit 3 for peer-delay response) goes to the second arrival record and leaves the first untouched. Any other qualifying arrival goes to the first.
- R6: A strobe with a non-matching EtherType, or with a message type whose capture-mask bit is clear, changes no record.
- R7: While the global off bit or the port off bit is 1, no strobe on either path changes any record.
- R8: A qualifying frame that targets a record that is already valid keeps valid, the time and the sequence ID, and sets the status field to 01 (overrun).
- R9: Writing 0 to a record's status word clears all four words. Writing a nonzero value to a status word, or any value to words +1..+3, has no effect.
- R10: A qualifying departure (`tx_*` inputs, same rules as R4, no steering) fills the departure record with the same layout and overrun rule, independently of the arrival records.
- R11: When a zero write to a status word and a qualifying frame for that record fall in the same cycle, the record ends up holding the new capture with status 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_sof | input | 1 | Arrival frame-start strobe |
| rx_etype | input | 16 | Parsed EtherType of the arriving frame |
| rx_msgtype | input | 4 | PTP message type of the arriving frame |
| rx_seqid | input | 16 | Sequence ID of the arriving frame |
| tx_sof | input | 1 | Departure frame-start strobe |
| tx_etype | input | 16 | Parsed EtherType of the departing frame |
| tx_msgtype | input | 4 | PTP message type of the departing frame |
| tx_seqid | input | 16 | Sequence ID of the departing frame |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 5 | Register word address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Registered read data |
| cur_time | output | 32 | Free-running time counter value |

## Verification
Capture is tried with frames that differ in only one qualifying field at a time: a wrong EtherType, a masked message type, a steered type, and strobes sent while each off bit is set. This shows which condition gates the capture and which record a frame lands in. Back-to-back frames into one record tell the overrun path apart from a plain overwrite. Same-cycle clear and capture tells the two possible priorities apart. Nonzero status writes and writes to the time and sequence words show that only a zero status write frees a record. Random mixes of frames on both paths, clears and mask changes are then compared word by word against a bench model of the three records.

// File: rtl/ptp_stamp_pkg.sv
package ptp_stamp_pkg;

  localparam int WORD_W  = 16;
  localparam int TIME_W  = 32;
  localparam int MSG_W   = 4;
  localparam int NUM_REC = 3;
  localparam int REC_DEP = NUM_REC - 1;

  typedef enum logic [1:0] {
    ST_NORMAL  = 2'b00,
    ST_OVERRUN = 2'b01
  } stamp_status_e;

  typedef struct packed {
    logic                valid;
    stamp_status_e       status;
    logic [TIME_W-1:0]   stamp;
    logic [WORD_W-1:0]   seq;
  } stamp_rec_t;

  // A frame qualifies when strobed, enabled, EtherType matches and type is in the mask.
  function automatic logic frame_qualifies(
    input logic               sof,
    input logic               enabled,
    input logic [WORD_W-1:0]  etype,
    input logic [WORD_W-1:0]  etype_cfg,
    input logic [MSG_W-1:0]   msgtype,
    input logic [WORD_W-1:0]  type_mask
  );
    return sof && enabled && (etype == etype_cfg) && type_mask[msgtype];
  endfunction

  function automatic logic [WORD_W-1:0] status_word(input stamp_rec_t r);
    logic [WORD_W-1:0] w;
    w      = '0;
    w[0]   = r.valid;
    w[2:1] = r.status;
    return w;
  endfunction

  // Word select within a record: 0 status, 1 time low, 2 time high, 3 sequence.
  function automatic logic [WORD_W-1:0] rec_word(input stamp_rec_t r, input logic [1:0] sel);
    case (sel)
      2'd0:    return status_word(r);
      2'd1:    return r.stamp[WORD_W-1:0];
      2'd2:    return r.stamp[TIME_W-1:WORD_W];
      default: return r.seq;
    endcase
  endfunction

endpackage

// File: rtl/stamp_counter.sv
module stamp_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] time_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) time_q <= '0;
    else        time_q <= time_q + W'(1);
  end

endmodule

// File: rtl/stamp_record.sv
module stamp_record
  import ptp_stamp_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cap,
  input  logic [TIME_W-1:0]  cap_stamp,
  input  logic [WORD_W-1:0]  cap_seq,
  input  logic               clr,
  output stamp_rec_t         rec,
  output logic               fill_evt,
  output logic               ovf_evt
);

  logic live_valid;

  // A clear in the same cycle frees the record before the capture looks at it.
  assign live_valid = rec.valid && !clr;
  assign fill_evt   = cap && !live_valid;
  assign ovf_evt    = cap && live_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rec <= '0;
    end else if (fill_evt) begin
      rec.valid  <= 1'b1;
      rec.status <= ST_NORMAL;
      rec.stamp  <= cap_stamp;
      rec.seq    <= cap_seq;
    end else if (ovf_evt) begin
      rec.status <= ST_OVERRUN;
    end else if (clr) begin
      rec <= '0;
    end
  end

endmodule

// File: rtl/stamp_regs.sv
module stamp_regs
  import ptp_stamp_pkg::*;
#(
  parameter int               ADDR_W      = 5,
  parameter logic [15:0]      ETYPE_RESET = 16'h88F7,
  parameter logic [15:0]      MASK_RESET  = 16'h000F,
  parameter logic [15:0]      STEER_RESET = 16'h0000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [WORD_W-1:0]  reg_wdata,
  input  stamp_rec_t         recs [NUM_REC],
  output logic [WORD_W-1:0]  reg_rdata,
  output logic               global_off,
  output logic               port_off,
  output logic [WORD_W-1:0]  etype_cfg,
  output logic [WORD_W-1:0]  type_mask,
  output logic [WORD_W-1:0]  steer_mask,
  output logic [NUM_REC-1:0] rec_clr
);

  localparam int REC_IDX_W = 2;
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_ETYPE = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_STEER = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_PORT  = ADDR_W'(4);

  logic                  in_rec;
  logic [REC_IDX_W-1:0]  rec_idx;
  logic [1:0]            rec_sel;
  logic [WORD_W-1:0]     rd_mux;

  assign in_rec  = reg_addr[ADDR_W-1];
  assign rec_idx = reg_addr[3:2];
  assign rec_sel = reg_addr[1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      global_off <= 1'b1;
      port_off   <= 1'b1;
      etype_cfg  <= ETYPE_RESET;
      type_mask  <= MASK_RESET;
      steer_mask <= STEER_RESET;
    end else if (reg_wr) begin
      case (reg_addr)
        A_CTRL:  global_off <= reg_wdata[0];
        A_ETYPE: etype_cfg  <= reg_wdata;
        A_MASK:  type_mask  <= reg_wdata;
        A_STEER: steer_mask <= reg_wdata;
        A_PORT:  port_off   <= reg_wdata[0];
        default: ;
      endcase
    end
  end

  // Only a zero written to a status word frees a record.
  for (genvar g = 0; g < NUM_REC; g++) begin : g_clr
    assign rec_clr[g] = reg_wr && in_rec && (rec_idx == REC_IDX_W'(g)) &&
                        (rec_sel == 2'd0) && (reg_wdata == '0);
  end

  always_comb begin
    rd_mux = '0;
    if (in_rec) begin
      for (int i = 0; i < NUM_REC; i++) begin
        if (rec_idx == REC_IDX_W'(i)) rd_mux = rec_word(recs[i], rec_sel);
      end
    end else begin
      case (reg_addr)
        A_CTRL:  rd_mux = {{(WORD_W-1){1'b0}}, global_off};
        A_ETYPE: rd_mux = etype_cfg;
        A_MASK:  rd_mux = type_mask;
        A_STEER: rd_mux = steer_mask;
        A_PORT:  rd_mux = {{(WORD_W-1){1'b0}}, port_off};
        default: rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end

endmodule

// File: rtl/ptp_stamp_unit.sv
module ptp_stamp_unit
  import ptp_stamp_pkg::*;
#(
  parameter int          ADDR_W      = 5,
  parameter logic [15:0] ETYPE_RESET = 16'h88F7,
  parameter logic [15:0] MASK_RESET  = 16'h000F
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rx_sof,
  input  logic [15:0]        rx_etype,
  input  logic [3:0]         rx_msgtype,
  input  logic [15:0]        rx_seqid,
  input  logic               tx_sof,
  input  logic [15:0]        tx_etype,
  input  logic [3:0]         tx_msgtype,
  input  logic [15:0]        tx_seqid,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [15:0]        reg_wdata,
  output logic [15:0]        reg_rdata,
  output logic [31:0]        cur_time
);

  logic               global_off;
  logic               port_off;
  logic               cap_enabled;
  logic [WORD_W-1:0]  etype_cfg;
  logic [WORD_W-1:0]  type_mask;
  logic [WORD_W-1:0]  steer_mask;
  logic               rx_hit;
  logic               rx_steer;
  logic               tx_hit;
  logic [NUM_REC-1:0] cap_vec;
  logic [NUM_REC-1:0] rec_clr;
  logic [NUM_REC-1:0] fill_vec;
  logic [NUM_REC-1:0] ovf_vec;
  stamp_rec_t         recs [NUM_REC];

  // Flattened record state for the checker.
  logic [NUM_REC-1:0]             rec_valid_w;
  logic [NUM_REC-1:0][1:0]        rec_status_w;
  logic [NUM_REC-1:0][TIME_W-1:0] rec_stamp_w;
  logic [NUM_REC-1:0][WORD_W-1:0] rec_seq_w;

  stamp_counter #(.W(TIME_W)) u_counter (
    .clk    (clk),
    .rst_n  (rst_n),
    .time_q (cur_time)
  );

  stamp_regs #(
    .ADDR_W      (ADDR_W),
    .ETYPE_RESET (ETYPE_RESET),
    .MASK_RESET  (MASK_RESET),
    .STEER_RESET (16'h0000)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .recs       (recs),
    .reg_rdata  (reg_rdata),
    .global_off (global_off),
    .port_off   (port_off),
    .etype_cfg  (etype_cfg),
    .type_mask  (type_mask),
    .steer_mask (steer_mask),
    .rec_clr    (rec_clr)
  );

  assign cap_enabled = !global_off && !port_off;
  assign rx_hit   = frame_qualifies(rx_sof, cap_enabled, rx_etype, etype_cfg, rx_msgtype, type_mask);
  assign tx_hit   = frame_qualifies(tx_sof, cap_enabled, tx_etype, etype_cfg, tx_msgtype, type_mask);
  assign rx_steer = steer_mask[rx_msgtype];

  assign cap_vec[0]       = rx_hit && !rx_steer;
  assign cap_vec[1]       = rx_hit && rx_steer;
  assign cap_vec[REC_DEP] = tx_hit;

  for (genvar g = 0; g < NUM_REC; g++) begin : g_rec
    logic [WORD_W-1:0] seq_in;
    if (g == REC_DEP) begin : g_dep
      assign seq_in = tx_seqid;
    end else begin : g_arr
      assign seq_in = rx_seqid;
    end

    stamp_record u_rec (
      .clk       (clk),
      .rst_n     (rst_n),
      .cap       (cap_vec[g]),
      .cap_stamp (cur_time),
      .cap_seq   (seq_in),
      .clr       (rec_clr[g]),
      .rec       (recs[g]),
      .fill_evt  (fill_vec[g]),
      .ovf_evt   (ovf_vec[g])
    );

    assign rec_valid_w[g]  = recs[g].valid;
    assign rec_status_w[g] = recs[g].status;
    assign rec_stamp_w[g]  = recs[g].stamp;
    assign rec_seq_w[g]    = recs[g].seq;
  end

endmodule

// File: rtl/ptp_stamp_unit_chk.sv
module ptp_stamp_unit_chk #(
  parameter int N  = 3,
  parameter int TW = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic [TW-1:0]       cur_time,
  input logic                global_off,
  input logic                port_off,
  input logic [N-1:0]        cap_vec,
  input logic [N-1:0]        fill_vec,
  input logic [N-1:0]        ovf_vec,
  input logic [N-1:0]        rec_clr,
  input logic [N-1:0]        rec_valid_w,
  input logic [N-1:0][1:0]   rec_status_w,
  input logic [N-1:0][TW-1:0] rec_stamp_w,
  input logic [N-1:0][15:0]  rec_seq_w
);

  p_count_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> cur_time == $past(cur_time) + TW'(1));

  p_off_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (global_off || port_off) |-> cap_vec == '0);

  p_one_arrival_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cap_vec[1:0]));

  for (genvar g = 0; g < N; g++) begin : g_rec_chk
    p_fill_good_r4: assert property (@(posedge clk) disable iff (!rst_n)
      fill_vec[g] |=> rec_valid_w[g] && rec_status_w[g] == 2'b00 &&
                      rec_stamp_w[g] == $past(cur_time));

    p_overrun_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_vec[g] |=> rec_valid_w[g] && rec_status_w[g] == 2'b01 &&
                     rec_stamp_w[g] == $past(rec_stamp_w[g]) &&
                     rec_seq_w[g] == $past(rec_seq_w[g]));

    p_clear_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rec_clr[g] && !cap_vec[g]) |=> !rec_valid_w[g] && rec_status_w[g] == 2'b00);

    p_valid_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rec_valid_w[g] && !rec_clr[g]) |=> rec_valid_w[g]);

    p_clear_then_fill_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (rec_clr[g] && cap_vec[g]) |-> fill_vec[g] && !ovf_vec[g]);
  end

endmodule

bind ptp_stamp_unit ptp_stamp_unit_chk #(.N(ptp_stamp_pkg::NUM_REC), .TW(ptp_stamp_pkg::TIME_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cur_time     (cur_time),
  .global_off   (global_off),
  .port_off     (port_off),
  .cap_vec      (cap_vec),
  .fill_vec     (fill_vec),
  .ovf_vec      (ovf_vec),
  .rec_clr      (rec_clr),
  .rec_valid_w  (rec_valid_w),
  .rec_status_w (rec_status_w),
  .rec_stamp_w  (rec_stamp_w),
  .rec_seq_w    (rec_seq_w)
);

// File: tb/ptp_stamp_unit_bench.sv
module ptp_stamp_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_sof = 1'b0, tx_sof = 1'b0;
  logic [15:0] rx_etype = '0, tx_etype = '0, rx_seqid = '0, tx_seqid = '0;
  logic [3:0]  rx_msgtype = '0, tx_msgtype = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [31:0] cur_time;

  int n_checks = 0;
  int n_fail = 0;

  ptp_stamp_unit u_ptp_stamp_unit (
    .clk, .rst_n, .rx_sof, .rx_etype, .rx_msgtype, .rx_seqid,
    .tx_sof, .tx_etype, .tx_msgtype, .tx_seqid,
    .reg_wr, .reg_rd, .reg_addr, .reg_wdata, .reg_rdata, .cur_time
  );

  always #5 clk = ~clk;

  // Bench time base, kept from the requirement (0 in reset, +1 per edge).
  logic [31:0] bcnt;
  always @(posedge clk) begin
    if (!rst_n) bcnt <= 0;
    else        bcnt <= bcnt + 1;
  end

  // Model of the three records and of the configuration.
  logic        mvalid [3];
  logic [1:0]  mstat  [3];
  logic [31:0] mtime  [3];
  logic [15:0] mseq   [3];
  logic        m_goff, m_poff;
  logic [15:0] m_etype, m_mask, m_steer;

  function automatic logic m_qual(input logic [15:0] et, input logic [3:0] mt);
    return !m_goff && !m_poff && et == m_etype && m_mask[mt];
  endfunction

  function automatic logic [15:0] exp_word(input int i, input int w);
    case (w)
      0:       return {13'b0, mstat[i], mvalid[i]};
      1:       return mtime[i][15:0];
      2:       return mtime[i][31:16];
      default: return mseq[i];
    endcase
  endfunction

  task automatic model_cap(input int i, input logic [31:0] t, input logic [15:0] s);
    if (mvalid[i]) mstat[i] = 2'b01;
    else begin mvalid[i] = 1'b1; mstat[i] = 2'b00; mtime[i] = t; mseq[i] = s; end
  endtask

  task automatic model_clr(input int i);
    mvalid[i] = 0; mstat[i] = 0; mtime[i] = 0; mseq[i] = 0;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
    case (a)
      5'h00: m_goff = d[0];
      5'h01: m_etype = d;
      5'h02: m_mask = d;
      5'h03: m_steer = d;
      5'h04: m_poff = d[0];
      default: if (a[4] && a[1:0] == 0 && a[3:2] != 3 && d == 0) model_clr(int'(a[3:2]));
    endcase
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    @(negedge clk); reg_rd = 0; d = reg_rdata;
  endtask

  task automatic rx(input logic [15:0] et, input logic [3:0] mt, input logic [15:0] s);
    logic [31:0] t;
    @(negedge clk); rx_sof = 1; rx_etype = et; rx_msgtype = mt; rx_seqid = s; t = bcnt;
    @(negedge clk); rx_sof = 0;
    if (m_qual(et, mt)) model_cap(m_steer[mt] ? 1 : 0, t, s);
  endtask

  task automatic tx(input logic [15:0] et, input logic [3:0] mt, input logic [15:0] s);
    logic [31:0] t;
    @(negedge clk); tx_sof = 1; tx_etype = et; tx_msgtype = mt; tx_seqid = s; t = bcnt;
    @(negedge clk); tx_sof = 0;
    if (m_qual(et, mt)) model_cap(2, t, s);
  endtask

  task automatic check_rec(input int i, input string req);
    logic [15:0] d;
    for (int w = 0; w < 4; w++) begin
      rd(5'h10 + 5'(i * 4 + w), d);
      chk(req, {16'h0, d}, {16'h0, exp_word(i, w)});
    end
  endtask

  initial begin : watchdog
    #1_000_000;
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin : main
    logic [15:0] d;
    logic [31:0] t;
    for (int i = 0; i < 3; i++) model_clr(i);
    m_goff = 1; m_poff = 1; m_etype = 16'h88F7; m_mask = 16'h000F; m_steer = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R2 reset values
    rd(5'h00, d); chk("R2 ctrl", d, 16'h0001);
    rd(5'h01, d); chk("R2 etype", d, 16'h88F7);
    rd(5'h02, d); chk("R2 mask", d, 16'h000F);
    rd(5'h03, d); chk("R2 steer", d, 16'h0000);
    rd(5'h04, d); chk("R2 port", d, 16'h0001);
    for (int i = 0; i < 3; i++) check_rec(i, "R2 record");
    rd(5'h1C, d); chk("R3 unmapped", d, 16'h0000);

    // R1 counter follows the bench time base
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); chk("R1 counter", cur_time, bcnt);
    end

    // R3 read latency: data not visible before the sampling edge
    rd(5'h01, d);
    @(negedge clk); reg_rd = 1; reg_addr = 5'h02; #1;
    chk("R3 before edge", reg_rdata, 16'h88F7);
    @(negedge clk); reg_rd = 0;
    chk("R3 after edge", reg_rdata, 16'h000F);

    // R7 port still off
    wr(5'h00, 16'h0000);
    rx(16'h88F7, 4'd0, 16'h1111);
    tx(16'h88F7, 4'd0, 16'h1112);
    check_rec(0, "R7 port off"); check_rec(2, "R7 port off");
    wr(5'h04, 16'h0000);

    // R4 basic arrival
    rx(16'h88F7, 4'd0, 16'h1234);
    check_rec(0, "R4 arrival");
    // R8 overrun
    rx(16'h88F7, 4'd1, 16'h5678);
    check_rec(0, "R8 overrun");
    // R9 ignored writes, then clear
    wr(5'h10, 16'h0005);
    wr(5'h11, 16'hABCD);
    wr(5'h13, 16'hBEEF);
    check_rec(0, "R9 ignored");
    wr(5'h10, 16'h0000);
    check_rec(0, "R9 clear");

    // R5 steering type 3
    wr(5'h03, 16'h0008);
    rx(16'h88F7, 4'd3, 16'h0303);
    check_rec(1, "R5 steered"); check_rec(0, "R5 first untouched");
    rx(16'h88F7, 4'd2, 16'h0202);
    check_rec(0, "R5 unsteered");
    wr(5'h10, 0); wr(5'h14, 0);

    // R6 mismatch
    rx(16'h0800, 4'd0, 16'h0600);
    rx(16'h88F7, 4'd5, 16'h0605);
    check_rec(0, "R6 mismatch"); check_rec(1, "R6 mismatch");

    // R10 departure
    tx(16'h88F7, 4'd2, 16'h0A0A);
    check_rec(2, "R10 departure"); check_rec(0, "R10 arrival untouched");
    tx(16'h88F7, 4'd0, 16'h0A0B);
    check_rec(2, "R10 overrun");
    wr(5'h18, 0);

    // R7 global off
    wr(5'h00, 16'h0001);
    rx(16'h88F7, 4'd0, 16'h0770);
    tx(16'h88F7, 4'd0, 16'h0771);
    check_rec(0, "R7 global off"); check_rec(2, "R7 global off");
    wr(5'h00, 16'h0000);

    // R11 clear and capture in one cycle
    rx(16'h88F7, 4'd0, 16'h0B00);
    @(negedge clk);
    reg_wr = 1; reg_addr = 5'h10; reg_wdata = 0;
    rx_sof = 1; rx_etype = 16'h88F7; rx_msgtype = 0; rx_seqid = 16'h0B11; t = bcnt;
    @(negedge clk); reg_wr = 0; rx_sof = 0;
    model_clr(0); model_cap(0, t, 16'h0B11);
    check_rec(0, "R11 same cycle");

    // Random phase against the model
    void'($urandom(32'd1588));
    for (int it = 0; it < 300; it++) begin
      int op;
      logic [15:0] et;
      op = int'($urandom_range(0, 7));
      et = ($urandom_range(0, 7) == 0) ? 16'h0800 : 16'h88F7;
      case (op)
        0, 1, 2: rx(et, 4'($urandom_range(0, 15)), 16'($urandom));
        3:       tx(et, 4'($urandom_range(0, 15)), 16'($urandom));
        4:       wr(5'h10 + 5'($urandom_range(0, 2) * 4), 16'h0000);
        5:       wr(5'h02, 16'($urandom) | 16'h0001);
        6:       wr(5'h03, 16'($urandom));
        default: check_rec(int'($urandom_range(0, 2)), "R4 random");
      endcase
    end
    for (int i = 0; i < 3; i++) check_rec(i, "R8 random final");

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule